// File: doc/BRIEF.md
# Unaligned Partial-Word Store Unit

This block converts a store-bytes request into a single aligned, big-endian memory word write with byte enables. A request carries a byte address, a register value and a mode select. The low address bits choose how many bytes are written. In begin mode the low-order register bytes are written from the addressed byte to the end of the word. In end mode the high-order register bytes are written from the start of the word up to the byte just below the address.

Every partial write, including the three-byte cases, leaves the block as one word write with a byte-enable mask, so memory sees it as one atomic update. The end-mode case with a zero offset writes no bytes. It still produces an access with an all-clear mask and a probe flag set, so the memory side can check write permission and mark the line dirty.

Both edges of the block are valid/ready streams. A request is taken on a clock edge when `req_valid` and `req_ready` are both high. Its write appears on the `wr_*` outputs one cycle later and stays there, unchanged, until `wr_ready` is seen high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle, so with `wr_ready` held high a new request is taken every cycle.

Top module: `stby_store_unit`

## Requirements
- R1: `wr_addr` equals the request address with its two low bits cleared.
- R2: Begin mode (`req_end`=0) with offset o = addr[1:0] enables the bytes at offsets o..3: `wr_be` = 2^(4-o)-1 (o=0: 1111, o=1: 0111, o=2: 0011, o=3: 0001).
- R3: End mode (`req_end`=1) with offset o≥1 enables the bytes at offsets 0..o-1: o=1: 1000, o=2: 1100, o=3: 1110.
- R4: End mode with offset 0 gives `wr_be`=0000 and `wr_probe`=1. `wr_probe` is 0 for every other request.
- R5: `wr_data` equals the request data in every case. Byte-enable bit 3 covers the lowest byte address, which is bus bits [31:24], and bit 0 covers bits [7:0].
- R6: An accepted request shows up on the outputs with `wr_valid`=1 exactly one cycle later. Responses come out in request order.
- R7: While `wr_valid`=1 and `wr_ready`=0, the outputs hold their values and `req_ready` is 0.
- R8: When `wr_ready`=1, `req_ready`=1, so back-to-back requests are taken on every cycle.
- R9: After reset `wr_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Register value |
| req_end | input | 1 | 0 = begin mode, 1 = end mode |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Downstream ready |
| wr_addr | output | 32 | Word-aligned address |
| wr_be | output | 4 | Byte enables, bit 3 = lowest address |
| wr_data | output | 32 | Write data on big-endian lanes |
| wr_probe | output | 1 | Zero-byte probe access |

## Verification
The bench sweeps both modes over all four offsets with several data and address patterns. The masks are mirror images of each other: a design that swaps them, reverses the lane order, or drops one byte from a three-byte case would show a wrong `wr_be` at that offset. The zero-offset end case is checked for an empty mask together with the probe flag, which catches a design that skips the access or raises the flag on the begin-mode full-word case. A stall phase holds `wr_ready` low while a second request waits, and checks that the first write stays stable and that the second is neither lost nor duplicated.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic {
    STBY_BEGIN = 1'b0,
    STBY_END   = 1'b1
  } stby_mode_e;
endpackage

// File: rtl/stby_mask_gen.sv
module stby_mask_gen
  import stby_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFS_W = $clog2(LANES)
) (
  input  stby_mode_e        mode,
  input  logic [OFS_W-1:0]  ofs,
  output logic [LANES-1:0]  be,
  output logic              probe
);
  // Enable bit j covers byte address LANES-1-j (big-endian lane order).
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int BYTE_POS = LANES - 1 - j;
    logic at_or_after;
    assign at_or_after = (OFS_W'(BYTE_POS) >= ofs);
    assign be[j] = (mode == STBY_BEGIN) ? at_or_after : !at_or_after;
  end

  assign probe = (mode == STBY_END) && (ofs == '0);
endmodule

// File: rtl/stby_resp_reg.sv
module stby_resp_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_payload,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_payload
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_payload <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_payload <= in_payload;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_payload)));

  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);
endmodule

// File: rtl/stby_store_unit.sv
module stby_store_unit
  import stby_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_end,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W/8-1:0] wr_be,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_probe
);
  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam int PAY_W = ADDR_W + LANES + DATA_W + 1;

  logic [OFS_W-1:0]  ofs;
  logic [LANES-1:0]  be_c;
  logic              probe_c;
  logic [ADDR_W-1:0] addr_c;
  logic [PAY_W-1:0]  pay_in, pay_out;
  stby_mode_e        mode;

  assign ofs    = req_addr[OFS_W-1:0];
  assign mode   = stby_mode_e'(req_end);
  assign addr_c = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

  stby_mask_gen #(.LANES(LANES), .OFS_W(OFS_W)) u_mask (
    .mode  (mode),
    .ofs   (ofs),
    .be    (be_c),
    .probe (probe_c)
  );

  // Lane placement is identity on a big-endian bus: begin mode fills the
  // low-order lanes with the low register bytes, end mode the high ones.
  assign pay_in = {addr_c, be_c, req_data, probe_c};

  stby_resp_reg #(.WIDTH(PAY_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (req_valid),
    .in_ready    (req_ready),
    .in_payload  (pay_in),
    .out_valid   (wr_valid),
    .out_ready   (wr_ready),
    .out_payload (pay_out)
  );

  assign {wr_addr, wr_be, wr_data, wr_probe} = pay_out;

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFS_W-1:0] == '0));

  assert_probe_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_probe) |-> (wr_be == '0));

  assert_nonprobe_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_probe) |-> (wr_be != '0));

  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> !wr_valid);
endmodule

// File: tb/stby_store_unit_test.sv
module stby_store_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_end;
  logic [31:0] req_addr, req_data;
  logic        wr_valid, wr_ready, wr_probe;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stby_store_unit uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_end(req_end),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data), .wr_probe(wr_probe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_be(input logic e, input int o);
    int n;
    if (!e) n = (1 << (4 - o)) - 1;
    else    n = (15 << (4 - o)) & 15;
    return n[3:0];
  endfunction

  task automatic check_out(input logic [31:0] a, input logic [31:0] d, input logic e);
    int o;
    o = int'(a[1:0]);
    chk("R6 wr_valid", {31'b0, wr_valid}, 32'd1);
    chk("R1 wr_addr", wr_addr, a & 32'hFFFF_FFFC);
    if (!e) chk("R2 begin be", {28'b0, wr_be}, {28'b0, exp_be(e, o)});
    else    chk("R3 end be", {28'b0, wr_be}, {28'b0, exp_be(e, o)});
    chk("R4 probe", {31'b0, wr_probe}, {31'b0, (e && o == 0)});
    chk("R5 wr_data", wr_data, d);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] pa, pd;
    logic pe;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_end = 1'b0;
    wr_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 wr_valid after reset", {31'b0, wr_valid}, 32'd0);
    chk("R9 req_ready after reset", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;

    // Back-to-back sweep: every mode and offset, several patterns.
    pe = 1'b0; pa = '0; pd = '0;
    for (int p = 0; p < 6; p++) begin
      for (int m = 0; m < 2; m++) begin
        for (int o = 0; o < 4; o++) begin
          logic [31:0] a, d;
          a = (32'h1357_9BD0 * (p + 1) + 32'h0000_0104 * m) & 32'hFFFF_FFFC;
          a = a | o;
          d = 32'hA1B2_C3D4 ^ (32'h0101_0101 * (p * 8 + m * 4 + o));
          req_valid = 1'b1; req_addr = a; req_data = d; req_end = m[0];
          chk("R8 req_ready with wr_ready", {31'b0, req_ready}, 32'd1);
          @(negedge clk);
          if (p + m + o != 0) begin end
          check_out(a, d, m[0]);
          pa = a; pd = d; pe = m[0];
        end
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 no extra response", {31'b0, wr_valid}, 32'd0);

    // Back-pressure: A accepted, B waits while output stalls.
    wr_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'h0000_4003; req_data = 32'h1122_3344; req_end = 1'b1;
    @(negedge clk);
    check_out(32'h0000_4003, 32'h1122_3344, 1'b1);
    req_addr = 32'h0000_8001; req_data = 32'h5566_7788; req_end = 1'b0;
    chk("R7 req_ready low when stalled", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk("R7 held addr", wr_addr, 32'h0000_4000);
    chk("R7 held be", {28'b0, wr_be}, 32'hE);
    chk("R7 held data", wr_data, 32'h1122_3344);
    wr_ready = 1'b1;
    @(negedge clk);
    check_out(32'h0000_8001, 32'h5566_7788, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 B delivered once", {31'b0, wr_valid}, 32'd0);

    // Probe-only under stall and release.
    wr_ready = 1'b0;
    req_valid = 1'b1; req_addr = 32'hFFFF_FFF0; req_data = 32'hDEAD_BEEF; req_end = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_out(32'hFFFF_FFF0, 32'hDEAD_BEEF, 1'b1);
    wr_ready = 1'b1;
    @(negedge clk);
    chk("R6 probe consumed", {31'b0, wr_valid}, 32'd0);
    if (pa == 32'h0 && pd == 32'h0 && pe) $display("note");
    finish_run();
  end
endmodule